// File: doc/BRIEF.md
# Order-Preserving Float Unpack Comparator

This block turns a packed signed floating-point code (sign bit on top, magnitude field below it) into keys that order the same way as the values they encode, so that sign tests, ReLU, two-input max and threshold decisions become plain unsigned integer compares. The key comes from one XOR per bit. The sign bit is replicated across the word by an arithmetic right shift and used as an XOR mask. No adder and no carry chain is involved, so no extra cycles are added.

Three codes are presented each cycle: operand A, operand B and a threshold. The block returns these outputs:
- the magnitude key and sign of A
- a full sortable key for A
- the ReLU of A
- a flag telling whether A lies strictly above the threshold
- whichever of A and B is larger

The logic is combinational. A parameter adds one output register stage, which is on by default.

Top module: `ordkey_cmp`

## Requirements
- R1: `sign_o` equals bit N-1 of `code_a`.
- R2: `mag_key_o` equals the low N-1 bits of `code_a` when its sign is 0, and the bitwise complement of those bits (that is, 2^(N-1)-1 minus them) when its sign is 1.
- R3: `sort_key_o` is the inverted sign placed above `mag_key_o`. As an unsigned number it orders codes by signed value: a sign-0 code is worth +m and a sign-1 code is worth -(m+0.5), where m is the low N-1 bits. Negative zero therefore sorts just below positive zero.
- R4: The code with sign 0 and all magnitude bits set (the positive infinity/NaN slot) gets sort key 2^N-1, the highest. The code with all bits set gets sort key 0, the lowest.
- R5: `relu_o` is all zeros when the sign of `code_a` is 1, and equals `code_a` otherwise.
- R6: `above_thr_o` is 1 exactly when `code_a` orders strictly above `thr_code` under R3. An equal code gives 0.
- R7: `max_o` returns the operand of `code_a`/`code_b` that orders higher under R3. On equal order it returns `code_a`.
- R8: With OUT_REG=1, each output reflects the inputs sampled at the previous rising clock edge, and an active-low `rst_n` clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_a | input | N | Operand A code |
| code_b | input | N | Operand B code |
| thr_code | input | N | Threshold code |
| sign_o | output | 1 | Sign of A |
| mag_key_o | output | N-1 | XOR-unpacked magnitude key of A |
| sort_key_o | output | N | Full sortable key of A |
| relu_o | output | N | ReLU of A |
| above_thr_o | output | 1 | A strictly above threshold |
| max_o | output | N | Larger of A and B |

## Verification
The bench first sweeps all 65,536 ordered pairs of 8-bit codes. In this sweep B is also the threshold, and the reference ordering is computed from the doubled signed worth of each code. The sweep separates same-sign pairs, where magnitude direction matters and reverses for negatives, from cross-sign pairs and from the positive/negative zero pair. Random triples with an independent threshold are then applied, along with directed extremes and a mid-run reset. These show that the threshold flag does not depend on B and that reset clears the registered outputs.

// File: rtl/ordkey_pkg.sv
package ordkey_pkg;

    localparam int unsigned OUT_REG_DEFAULT = 1;

    typedef enum logic [1:0] {
        ORD_LT = 2'd0,
        ORD_EQ = 2'd1,
        ORD_GT = 2'd2
    } ord_rel_e;

endpackage

// File: rtl/ordkey_unpack.sv
module ordkey_unpack #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] code,
    output logic         sign,
    output logic [N-2:0] mag_key,
    output logic [N-1:0] sort_key
);
    logic [N-1:0] sign_mask;
    logic [N-1:0] xored;

    always_comb begin
        // arithmetic shift replicates the sign bit over the whole word
        sign_mask = N'($signed(code) >>> (N - 1));
        xored     = code ^ sign_mask;
        sign      = sign_mask[0];
        mag_key   = xored[N-2:0];
        sort_key  = {~code[N-1], xored[N-2:0]};
    end
endmodule

// File: rtl/ordkey_select.sv
module ordkey_select
    import ordkey_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] code_a,
    input  logic [N-1:0] code_b,
    input  logic [N-1:0] key_a,
    input  logic [N-1:0] key_b,
    input  logic [N-1:0] key_t,
    output logic [N-1:0] max_code,
    output logic         above
);
    ord_rel_e rel_ab;
    ord_rel_e rel_at;

    function automatic ord_rel_e relate(input logic [N-1:0] x, input logic [N-1:0] y);
        if (x > y)       return ORD_GT;
        else if (x == y) return ORD_EQ;
        else             return ORD_LT;
    endfunction

    always_comb begin
        rel_ab = relate(key_a, key_b);
        rel_at = relate(key_a, key_t);
        unique case (rel_ab)
            ORD_GT, ORD_EQ: max_code = code_a;
            default:        max_code = code_b;
        endcase
        above = (rel_at == ORD_GT);
    end
endmodule

// File: rtl/ordkey_outreg.sv
module ordkey_outreg #(
    parameter int unsigned W  = 8,
    parameter int unsigned EN = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (EN != 0) begin : g_reg
            logic [W-1:0] q_r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q_r <= '0;
                else        q_r <= d;
            end
            assign q = q_r;
        end else begin : g_pass
            logic unused_ok;
            assign unused_ok = clk ^ rst_n;
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/ordkey_cmp.sv
module ordkey_cmp
    import ordkey_pkg::*;
#(
    parameter int unsigned N       = 8,
    parameter int unsigned OUT_REG = OUT_REG_DEFAULT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] code_a,
    input  logic [N-1:0] code_b,
    input  logic [N-1:0] thr_code,
    output logic         sign_o,
    output logic [N-2:0] mag_key_o,
    output logic [N-1:0] sort_key_o,
    output logic [N-1:0] relu_o,
    output logic         above_thr_o,
    output logic [N-1:0] max_o
);
    localparam int unsigned BUS_W = 4 * N + 1;

    logic         sign_a, sign_b, sign_t;
    logic [N-2:0] mag_a, mag_b, mag_t;
    logic [N-1:0] key_a, key_b, key_t;
    logic [N-1:0] max_c;
    logic         above_c;
    logic [N-1:0] relu_c;
    logic [BUS_W-1:0] bus_d, bus_q;

    ordkey_unpack #(.N(N)) u_unpack_a (.code(code_a),   .sign(sign_a), .mag_key(mag_a), .sort_key(key_a));
    ordkey_unpack #(.N(N)) u_unpack_b (.code(code_b),   .sign(sign_b), .mag_key(mag_b), .sort_key(key_b));
    ordkey_unpack #(.N(N)) u_unpack_t (.code(thr_code), .sign(sign_t), .mag_key(mag_t), .sort_key(key_t));

    ordkey_select #(.N(N)) u_select (
        .code_a   (code_a),
        .code_b   (code_b),
        .key_a    (key_a),
        .key_b    (key_b),
        .key_t    (key_t),
        .max_code (max_c),
        .above    (above_c)
    );

    logic unused_side;
    assign unused_side = sign_b ^ sign_t ^ (^mag_b) ^ (^mag_t);

    always_comb begin
        relu_c = sign_a ? '0 : code_a;
        bus_d  = {sign_a, mag_a, key_a, relu_c, above_c, max_c};
    end

    ordkey_outreg #(.W(BUS_W), .EN(OUT_REG)) u_outreg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_d),
        .q     (bus_q)
    );

    assign {sign_o, mag_key_o, sort_key_o, relu_o, above_thr_o, max_o} = bus_q;

    generate
        if (OUT_REG != 0) begin : g_chk
            logic past_ok;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) past_ok <= 1'b0;
                else        past_ok <= 1'b1;
            end

            p_sign_follows_r1: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
                sign_o == $past(code_a[N-1]));

            p_key_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
                sort_key_o[N-1] != sign_o || (sort_key_o == '0 && !past_ok));

            p_relu_nonneg_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (relu_o != '0) |-> !sign_o);

            p_above_strict_r6: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
                above_thr_o |-> ($past(code_a) != $past(thr_code)));

            p_max_member_r7: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
                (max_o == $past(code_a)) || (max_o == $past(code_b)));
        end
    endgenerate
endmodule

// File: tb/ordkey_cmp_tb.sv
module ordkey_cmp_tb_top;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] code_a = '0, code_b = '0, thr_code = '0;
    logic         sign_o, above_thr_o;
    logic [N-2:0] mag_key_o;
    logic [N-1:0] sort_key_o, relu_o, max_o;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    ordkey_cmp #(.N(N), .OUT_REG(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .code_a(code_a), .code_b(code_b), .thr_code(thr_code),
        .sign_o(sign_o), .mag_key_o(mag_key_o), .sort_key_o(sort_key_o), .relu_o(relu_o),
        .above_thr_o(above_thr_o), .max_o(max_o)
    );

    // doubled signed worth: +m -> 2m, negative -> -(2m+1)
    function automatic int worth(input logic [N-1:0] c);
        int m = int'(c[N-2:0]);
        return c[N-1] ? -(2 * m + 1) : 2 * m;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [N-1:0] a, input logic [N-1:0] b, input logic [N-1:0] t);
        int m;
        @(negedge clk);
        code_a = a; code_b = b; thr_code = t;
        @(negedge clk);
        m = int'(a[N-2:0]);
        chk("R1 sign", int'(sign_o), int'(a[N-1]));
        chk("R2 mag_key", int'(mag_key_o), a[N-1] ? (2 ** (N - 1) - 1 - m) : m);
        chk("R3 sort_key", int'(sort_key_o), (worth(a) + 2 ** N) / 2);
        chk("R5 relu", int'(relu_o), a[N-1] ? 0 : int'(a));
        chk("R6 above", int'(above_thr_o), int'(worth(a) > worth(t)));
        chk("R7 max", int'(max_o), (worth(a) >= worth(b)) ? int'(a) : int'(b));
    endtask

    initial begin
        while (cycles < 195000) begin
            @(posedge clk);
            cycles++;
        end
        bad++;
        total++;
        $display("FAIL watchdog act=%0d exp=<195000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int s;
        s = $urandom(77);
        repeat (2) @(negedge clk);
        // R8 reset state
        chk("R8 reset max", int'(max_o), 0);
        chk("R8 reset key", int'(sort_key_o), 0);
        chk("R8 reset above", int'(above_thr_o), 0);
        rst_n = 1'b1;

        // R4 extremes
        apply(8'h7F, 8'hFF, 8'h00);
        chk("R4 top key", int'(sort_key_o), 255);
        apply(8'hFF, 8'h7F, 8'h80);
        chk("R4 bottom key", int'(sort_key_o), 0);
        // zeros: -0 below +0
        apply(8'h80, 8'h00, 8'h00);
        chk("R3 negzero below", int'(max_o), 8'h00);
        apply(8'h00, 8'h80, 8'h80);
        chk("R6 poszero above negzero", int'(above_thr_o), 1);
        // R7 tie
        apply(8'h35, 8'h35, 8'h35);
        chk("R7 tie", int'(max_o), 8'h35);

        // exhaustive pairs, threshold = B
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                apply(N'(a), N'(b), N'(b));

        // random triples with independent threshold
        for (int i = 0; i < 1500; i++)
            apply(N'($urandom), N'($urandom), N'($urandom));

        // R8 mid-run reset clears outputs
        apply(8'h12, 8'h34, 8'h00);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R8 midrun reset relu", int'(relu_o), 0);
        chk("R8 midrun reset max", int'(max_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        apply(8'h05, 8'h83, 8'h04);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule